// File: doc/BRIEF.md
# Input Source and Gain Control Decoder

This block turns a 5-bit control word into the digital controls of a front-end input stage. It produces eight switch enables (four differential pairs), a 3-bit gain code for the programmable amplifier, and two power-down flags. The upper two bits of the control word choose the source. The lower three bits choose the gain, or one of the special modes. The analog switches, the amplifier and the resistor networks sit outside the block. Only their enables are produced here.

Whenever the switch set has to change, the new set does not take over at once. All eight enables drop to zero for `DEAD_CYCLES` system-clock cycles, and only then does the new set close. A monitor watches the sampled modulator clock. When that clock stops toggling, it forces a whole-chip power-down. In any power-down the switches are parked on the ground input.

Switch enable bit order: bit0 S1+, bit1 S1-, bit2 S2+, bit3 S2-, bit4 S3+, bit5 S3-, bit6 S4+, bit7 S4-. The pairs are: S1 = signal input, S2 = test input, S3 = ground, S4 = reference. Gain codes 0..4 mean gains of 1, 2.5, 8.5, 34 and 128.

Top module: `inmux_gain_dec`

## Requirements
- R1: While reset is held, sw_en is 8'h30, gain_sel is 0, and pga_pd, chip_pd and mod_clk_lost are 0.
- R2: For ctrl_code[4:3] of 00, 01 or 10 with ctrl_code[2:0] from 0 to 4, sw_en settles to 8'h30, 8'h0C or 8'h03 respectively, and gain_sel equals ctrl_code[2:0].
- R3: Code 11000 selects the reference pair only (sw_en 8'h C0 written 8'hC0), with gain_sel forced to 0.
- R4: Code 11001 closes both the signal and the test pairs (8'h0F). Code 11010 closes S1+, S2+ and S2- (8'h0D). Both force gain_sel to 0.
- R5: When ctrl_code[2:0] is 101 and ctrl_code[2:1] is not 11, pga_pd is 1, chip_pd is 0, gain_sel is 0, and sw_en settles to 8'h30.
- R6: When ctrl_code[2] and ctrl_code[1] are both 1, chip_pd and pga_pd are 1, gain_sel is 0, and sw_en settles to 8'h30.
- R7: If mod_clk shows no edge for STOP_CYCLES system cycles, mod_clk_lost and chip_pd rise and the switches park on 8'h30. On the next edge both clear within a few cycles, and the code-selected configuration returns.
- R8: gain_sel, pga_pd and chip_pd follow ctrl_code one clock later. When the switch set changes, sw_en is 0 for exactly DEAD_CYCLES cycles from that same clock, and then shows the new set.
- R9: A code change that keeps the same switch set (for example, a gain-only change) updates gain_sel without opening the switches.
- R10: Unlisted codes 11011 and 11100 select the ground pair at gain 0 with no power-down flag.
- R11: If a different switch set is requested during the dead time, the dead time restarts. Only the newest set closes, and the earlier one never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_clk | input | 1 | Modulator clock, asynchronous to clk_sys, watched for activity |
| ctrl_code | input | 5 | Source, gain and power-down control word |
| sw_en | output | 8 | Switch enables, S1+ at bit 0 through S4- at bit 7 |
| gain_sel | output | 3 | Amplifier gain code 0..4 |
| pga_pd | output | 1 | Input multiplexer and amplifier power-down |
| chip_pd | output | 1 | Whole-chip power-down (code or stopped clock) |
| mod_clk_lost | output | 1 | Modulator clock declared stopped |

## Verification
Two functions can act in the same cycle. A power-down raised by the clock monitor, or by the code, changes the target switch set. That change must still go through the open-all dead time, while gain and flags switch at once. The bench provokes this by stopping the modulator clock while the signal pair is closed. It then checks that chip_pd rises inside a bounded window, that the switches open and then park on ground, and that after the clock restarts the signal pair closes again only after a full dead time. Separately, a second switch change is requested in the middle of a dead time, and the bench checks that the earlier target never shows on sw_en.

// File: rtl/inmux_pkg.sv
// Shared switch encodings and gain codes for the input decoder.
// Bit order of a switch vector: S1+,S1-,S2+,S2-,S3+,S3-,S4+,S4- from bit 0.
package inmux_pkg;
    typedef logic [7:0] sw_vec_t;
    typedef logic [2:0] gain_t;

    localparam sw_vec_t SW_NONE = 8'h00;
    localparam sw_vec_t SW_SIG  = 8'h03;
    localparam sw_vec_t SW_TST  = 8'h0C;
    localparam sw_vec_t SW_GND  = 8'h30;
    localparam sw_vec_t SW_REF  = 8'hC0;
    localparam sw_vec_t SW_ST1  = 8'h0F;
    localparam sw_vec_t SW_ST2  = 8'h0D;

    localparam gain_t GAIN_UNITY = 3'd0;
    localparam gain_t GAIN_MAX   = 3'd4;
endpackage

// File: rtl/inmux_clk_watch.sv
// Modulator clock activity monitor.
// Samples mod_clk through a SYNC_STAGES-deep synchronizer, detects edges and
// declares the clock lost after STOP_CYCLES system cycles without an edge.
// Assumes clk_sys runs more than twice as fast as mod_clk. Releases on the
// first edge that is seen.
module inmux_clk_watch #(
    parameter int SYNC_STAGES = 2,
    parameter int STOP_CYCLES = 64
) (
    input  logic clk_sys,
    input  logic rst_n,
    input  logic mod_clk,
    output logic lost
);
    localparam int CW = $clog2(STOP_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(STOP_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   seen_edge;
    logic [CW-1:0]          idle_q;
    logic                   lost_q;

    // Purpose: move mod_clk into the clk_sys domain.
    always_ff @(posedge clk_sys) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], mod_clk};
    end

    // Purpose: hold the last synchronized level for edge detection.
    always_ff @(posedge clk_sys) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign seen_edge = sync_q[SYNC_STAGES-1] ^ prev_q;

    // Purpose: count idle cycles and flag a stopped clock.
    always_ff @(posedge clk_sys) begin
        if (!rst_n) begin
            idle_q <= '0;
            lost_q <= 1'b0;
        end else if (seen_edge) begin
            idle_q <= '0;
            lost_q <= 1'b0;
        end else if (idle_q == LIMIT) begin
            lost_q <= 1'b1;
        end else begin
            idle_q <= idle_q + 1'b1;
        end
    end

    assign lost = lost_q;

    // R7: an observed edge always releases the stopped flag.
    a_r7_edge_releases: assert property (@(posedge clk_sys) disable iff (!rst_n)
        $past(seen_edge) |-> !lost_q);

    // R7: the flag only rises once the idle window is used up.
    a_r7_rise_after_idle: assert property (@(posedge clk_sys) disable iff (!rst_n)
        $rose(lost_q) |-> $past(idle_q) == LIMIT);
endmodule

// File: rtl/inmux_code_decode.sv
// Combinational decode of the control word into a target switch set,
// gain code and power-down flags. Priority: chip power-down (code or lost
// clock), then amplifier power-down, then the source/gain table. Any
// remaining unlisted code selects ground at unity gain.
module inmux_code_decode
    import inmux_pkg::*;
(
    input  logic [4:0] code,
    input  logic       clk_lost,
    output sw_vec_t    sw_target,
    output gain_t      gain_target,
    output logic       pga_off,
    output logic       chip_off
);
    logic [1:0] src;
    logic [2:0] low;

    assign src = code[4:3];
    assign low = code[2:0];

    // Purpose: resolve power-down priority.
    always_comb begin
        chip_off = (low[2] & low[1]) | clk_lost;
        pga_off  = chip_off | (low == 3'b101);
    end

    // Purpose: look up switch set and gain for the active mode.
    always_comb begin
        sw_target   = SW_GND;
        gain_target = GAIN_UNITY;
        if (!pga_off) begin
            unique case (src)
                2'b00: begin
                    sw_target   = SW_GND;
                    gain_target = (low <= GAIN_MAX) ? low : GAIN_UNITY;
                end
                2'b01: begin
                    sw_target   = (low <= GAIN_MAX) ? SW_TST : SW_GND;
                    gain_target = (low <= GAIN_MAX) ? low : GAIN_UNITY;
                end
                2'b10: begin
                    sw_target   = (low <= GAIN_MAX) ? SW_SIG : SW_GND;
                    gain_target = (low <= GAIN_MAX) ? low : GAIN_UNITY;
                end
                default: begin
                    unique case (low)
                        3'b000:  sw_target = SW_REF;
                        3'b001:  sw_target = SW_ST1;
                        3'b010:  sw_target = SW_ST2;
                        default: sw_target = SW_GND;
                    endcase
                    gain_target = GAIN_UNITY;
                end
            endcase
        end
    end
endmodule

// File: rtl/inmux_bbm_seq.sv
// Break-before-make sequencer for the switch enables.
// On any change of the target set, all enables open for DEAD_CYCLES system
// cycles, then the latest target closes. A new target during the dead time
// restarts it. Assumes DEAD_CYCLES >= 1.
module inmux_bbm_seq
    import inmux_pkg::*;
#(
    parameter int DEAD_CYCLES = 4
) (
    input  logic    clk_sys,
    input  logic    rst_n,
    input  sw_vec_t sw_target,
    output sw_vec_t sw_out
);
    localparam int DW = $clog2(DEAD_CYCLES + 1);
    localparam logic [DW-1:0] DEAD_LOAD = DW'(DEAD_CYCLES);
    localparam logic [DW-1:0] LAST_TICK = DW'(1);

    sw_vec_t       tgt_q;
    sw_vec_t       sw_q;
    logic [DW-1:0] cnt_q;

    // Purpose: open on change, count the dead time, then close the new set.
    always_ff @(posedge clk_sys) begin
        if (!rst_n) begin
            tgt_q <= SW_GND;
            sw_q  <= SW_GND;
            cnt_q <= '0;
        end else if (sw_target != tgt_q) begin
            tgt_q <= sw_target;
            sw_q  <= SW_NONE;
            cnt_q <= DEAD_LOAD;
        end else if (cnt_q == LAST_TICK) begin
            sw_q  <= tgt_q;
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign sw_out = sw_q;

    // R8: one closed set never turns directly into another.
    a_r8_open_before_close: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (sw_q != SW_NONE && $past(sw_q) != SW_NONE) |-> sw_q == $past(sw_q));

    // R8: everything stays open while the dead time runs.
    a_r8_open_during_dead: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (cnt_q != '0) |-> sw_q == SW_NONE);

    // R11: only the latest requested set is ever closed.
    a_r11_latest_only: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (sw_q != SW_NONE) |-> sw_q == tgt_q);
endmodule

// File: rtl/inmux_gain_dec.sv
// Top of the input source and gain control decoder.
// Registers gain and power-down flags one cycle after the control word,
// sequences switch enables break-before-make, and forces whole-chip
// power-down when the modulator clock stops. Assumes ctrl_code is
// synchronous to clk_sys.
module inmux_gain_dec
    import inmux_pkg::*;
#(
    parameter int DEAD_CYCLES = 4,
    parameter int STOP_CYCLES = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_sys,
    input  logic       rst_n,
    input  logic       mod_clk,
    input  logic [4:0] ctrl_code,
    output logic [7:0] sw_en,
    output logic [2:0] gain_sel,
    output logic       pga_pd,
    output logic       chip_pd,
    output logic       mod_clk_lost
);
    logic    lost;
    sw_vec_t sw_target;
    gain_t   gain_target;
    logic    pga_off;
    logic    chip_off;
    sw_vec_t sw_seq;
    gain_t   gain_q;
    logic    pga_q;
    logic    chip_q;

    inmux_clk_watch #(
        .SYNC_STAGES(SYNC_STAGES),
        .STOP_CYCLES(STOP_CYCLES)
    ) u_watch (
        .clk_sys (clk_sys),
        .rst_n   (rst_n),
        .mod_clk (mod_clk),
        .lost    (lost)
    );

    inmux_code_decode u_decode (
        .code        (ctrl_code),
        .clk_lost    (lost),
        .sw_target   (sw_target),
        .gain_target (gain_target),
        .pga_off     (pga_off),
        .chip_off    (chip_off)
    );

    inmux_bbm_seq #(
        .DEAD_CYCLES(DEAD_CYCLES)
    ) u_bbm (
        .clk_sys   (clk_sys),
        .rst_n     (rst_n),
        .sw_target (sw_target),
        .sw_out    (sw_seq)
    );

    // Purpose: register gain and power-down flags for glitch-free outputs.
    always_ff @(posedge clk_sys) begin
        if (!rst_n) begin
            gain_q <= GAIN_UNITY;
            pga_q  <= 1'b0;
            chip_q <= 1'b0;
        end else begin
            gain_q <= gain_target;
            pga_q  <= pga_off;
            chip_q <= chip_off;
        end
    end

    assign sw_en        = sw_seq;
    assign gain_sel     = gain_q;
    assign pga_pd       = pga_q;
    assign chip_pd      = chip_q;
    assign mod_clk_lost = lost;

    // R6: in chip power-down the switches are open or parked on ground.
    a_r6_chip_parked: assert property (@(posedge clk_sys) disable iff (!rst_n)
        chip_q |-> (sw_seq == SW_NONE || sw_seq == SW_GND));

    // R5: in amplifier power-down the switches are open or parked on ground.
    a_r5_pga_parked: assert property (@(posedge clk_sys) disable iff (!rst_n)
        pga_q |-> (sw_seq == SW_NONE || sw_seq == SW_GND));

    // R2: the gain code never leaves its legal range.
    a_r2_gain_legal: assert property (@(posedge clk_sys) disable iff (!rst_n)
        gain_q <= GAIN_MAX);

    // R3: the reference pair is only ever closed at unity gain.
    a_r3_ref_unity: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (sw_seq == SW_REF) |-> gain_q == GAIN_UNITY);

    // R6: a chip power-down always carries the amplifier power-down.
    a_r6_chip_implies_pga: assert property (@(posedge clk_sys) disable iff (!rst_n)
        chip_q |-> pga_q);
endmodule

// File: tb/sim_inmux_gain_dec.sv
module sim_inmux_gain_dec;
    localparam int CLK_PERIOD = 10;
    localparam int DEAD = 4;
    localparam int STOP = 32;
    localparam int WATCHDOG = 100000;

    logic       clk_sys = 1'b0;
    logic       rst_n = 1'b0;
    logic       mod_clk = 1'b0;
    logic [4:0] ctrl_code = 5'd0;
    logic [7:0] sw_en;
    logic [2:0] gain_sel;
    logic       pga_pd;
    logic       chip_pd;
    logic       mod_clk_lost;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic mclk_run = 1'b1;
    int div = 0;
    logic [7:0] prev_sw = 8'h30;

    inmux_gain_dec #(.DEAD_CYCLES(DEAD), .STOP_CYCLES(STOP)) u0 (
        .clk_sys(clk_sys), .rst_n(rst_n), .mod_clk(mod_clk),
        .ctrl_code(ctrl_code), .sw_en(sw_en), .gain_sel(gain_sel),
        .pga_pd(pga_pd), .chip_pd(chip_pd), .mod_clk_lost(mod_clk_lost));

    always #(CLK_PERIOD/2) clk_sys = ~clk_sys;

    // modulator clock: one toggle every three system cycles while running
    always @(negedge clk_sys) begin
        if (mclk_run) begin
            if (div == 0) mod_clk <= ~mod_clk;
            div <= (div == 2) ? 0 : div + 1;
        end else begin
            div <= 0;
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk_sys) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            failures = failures + 1;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic e_chip(input logic [4:0] c);
        return c[2] & c[1];
    endfunction

    function automatic logic e_pga(input logic [4:0] c);
        return e_chip(c) | (c[2:0] == 3'b101);
    endfunction

    function automatic logic [7:0] e_sw(input logic [4:0] c);
        if (e_pga(c)) return 8'h30;
        if (c[4:3] == 2'b11) begin
            if (c[2:0] == 3'd0) return 8'hC0;
            if (c[2:0] == 3'd1) return 8'h0F;
            if (c[2:0] == 3'd2) return 8'h0D;
            return 8'h30;
        end
        if (c[2:0] > 3'd4) return 8'h30;
        if (c[4:3] == 2'b01) return 8'h0C;
        if (c[4:3] == 2'b10) return 8'h03;
        return 8'h30;
    endfunction

    function automatic logic [2:0] e_gain(input logic [4:0] c);
        if (e_pga(c) || c[4:3] == 2'b11 || c[2:0] > 3'd4) return 3'd0;
        return c[2:0];
    endfunction

    function automatic string tag(input logic [4:0] c);
        if (e_chip(c)) return "R6";
        if (e_pga(c)) return "R5";
        if (c == 5'b11000) return "R3";
        if (c == 5'b11001 || c == 5'b11010) return "R4";
        if (c[4:3] == 2'b11) return "R10";
        return "R2";
    endfunction

    // drive a code at a negedge and check flags, dead time and settled set
    task automatic apply(input logic [4:0] c);
        logic [7:0] exp_sw;
        exp_sw = e_sw(c);
        ctrl_code = c;
        @(negedge clk_sys);
        chk({tag(c), " gain"}, gain_sel, e_gain(c));
        chk({tag(c), " pga_pd"}, pga_pd, e_pga(c));
        chk({tag(c), " chip_pd"}, chip_pd, e_chip(c));
        if (exp_sw != prev_sw) begin
            chk("R8 open at first cycle", sw_en, 0);
            repeat (DEAD - 1) @(negedge clk_sys);
            chk("R8 open at last dead cycle", sw_en, 0);
        end else begin
            chk("R9 same set stays closed", sw_en, prev_sw);
            repeat (DEAD - 1) @(negedge clk_sys);
        end
        @(negedge clk_sys);
        chk({tag(c), " R8 settled switches"}, sw_en, exp_sw);
        prev_sw = exp_sw;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1555);
        // R1: reset values
        repeat (4) @(negedge clk_sys);
        chk("R1 sw_en", sw_en, 8'h30);
        chk("R1 gain", gain_sel, 0);
        chk("R1 pga_pd", pga_pd, 0);
        chk("R1 chip_pd", chip_pd, 0);
        chk("R1 lost", mod_clk_lost, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk_sys);

        // directed corners
        apply(5'b10000);
        apply(5'b10100);   // R9 gain-only change
        apply(5'b01011);
        apply(5'b11000);   // R3
        apply(5'b11001);   // R4
        apply(5'b11010);   // R4
        apply(5'b00101);   // R5
        apply(5'b10110);   // R6
        apply(5'b11011);   // R10
        apply(5'b11100);   // R10
        apply(5'b00011);

        // R11: new set requested two cycles into a dead time
        apply(5'b10000);
        ctrl_code = 5'b01000;
        repeat (2) @(negedge clk_sys);
        chk("R11 open before retarget", sw_en, 0);
        ctrl_code = 5'b10011;
        for (int k = 1; k <= DEAD; k++) begin
            @(negedge clk_sys);
            chk("R11 open during restarted dead time", sw_en, 0);
        end
        @(negedge clk_sys);
        chk("R11 newest set closes", sw_en, 8'h03);
        chk("R11 gain of newest code", gain_sel, 3);
        prev_sw = 8'h03;

        // R7: stop the modulator clock while the signal pair is closed
        mclk_run = 1'b0;
        repeat (STOP - 1) @(negedge clk_sys);
        chk("R7 not lost before window", mod_clk_lost, 0);
        repeat (6) @(negedge clk_sys);
        chk("R7 lost after window", mod_clk_lost, 1);
        chk("R7 chip_pd forced", chip_pd, 1);
        chk("R7 pga_pd forced", pga_pd, 1);
        chk("R7 gain unity", gain_sel, 0);
        repeat (DEAD + 1) @(negedge clk_sys);
        chk("R7 parked on ground", sw_en, 8'h30);
        mclk_run = 1'b1;
        repeat (5) @(negedge clk_sys);
        chk("R7 released after edge", mod_clk_lost, 0);
        chk("R7 chip_pd released", chip_pd, 0);
        chk("R7 gain restored", gain_sel, 3);
        repeat (DEAD + 1) @(negedge clk_sys);
        chk("R7 signal pair back", sw_en, 8'h03);

        // random codes
        for (int i = 0; i < 250; i++) begin
            apply(5'($urandom % 32));
        end

        summary();
        $finish;
    end
endmodule